// File: doc/BRIEF.md
# Compact 32-bit Integer ALU

This block is a purely combinational arithmetic logic unit. It takes two operands of equal width, 32 bits by default, and a 3-bit operation code, and it returns one result word of the same width. It supports five operations: addition, subtraction, bitwise AND, bitwise OR and a signed set-less-than. Addition, subtraction and the comparison all share one ripple adder. For subtraction and comparison, the second operand is inverted and a carry of one is fed in.

The comparison does not use a separate magnitude comparator. It takes the sign of the difference A−B and XORs it with the signed overflow of that difference. The single answer bit is placed in bit 0 of the result. The three operation codes that are not assigned give an all-zero result. The block has no clock and no reset, and its output follows its inputs after the combinational delay.

Top module: `alu32`

## Requirements
- R1: Operation code 3'b000 gives A+B modulo 2^32.
- R2: Operation code 3'b001 gives A−B modulo 2^32.
- R3: Operation code 3'b010 gives the bitwise AND of A and B.
- R4: Operation code 3'b011 gives the bitwise OR of A and B.
- R5: With operation code 3'b101, bit 0 of the result is 1 exactly when A is less than B as two's-complement signed values. This holds where A−B overflows, for example 0x80000000 against 1 and 0x7FFFFFFF against 0xFFFFFFFF.
- R6: With operation code 3'b101, result bits 31 down to 1 are zero.
- R7: Operation codes 3'b100, 3'b110 and 3'b111 give an all-zero result for any operands.
- R8: Internally, at most one result source (sum, AND, OR, compare) is selected for any operation code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opCode | input | 3 | Operation select |
| result | output | 32 | Result of the selected operation |

## Verification
Assertions inside the RTL are evaluated whenever the inputs change. They check that at most one result source is selected, and that the adder output matches A+B or A−B when it is selected. They also check that the compare bit agrees with a signed comparison, and that unassigned codes give zero. These assertions watch the internal strobes and the adder.

The bench's reference model is what shows the results at the ports. It covers the overflow corners of the compare and the wrap-around of sums. It also sweeps every operation code, including the unassigned ones, over directed and random operands.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam logic [2:0] OP_ADD = 3'b000;
  localparam logic [2:0] OP_SUB = 3'b001;
  localparam logic [2:0] OP_AND = 3'b010;
  localparam logic [2:0] OP_OR  = 3'b011;
  localparam logic [2:0] OP_SLT = 3'b101;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic invertB;
    logic carryIn;
    logic selSum;
    logic selAnd;
    logic selOr;
    logic selSlt;
  } aluCtrl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [2:0] opCode,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl = '0;
    // low code bit drives both the operand inversion and the carry-in
    ctrl.invertB = opCode[0];
    ctrl.carryIn = opCode[0];
    case (opCode)
      OP_ADD, OP_SUB: ctrl.selSum = 1'b1;
      OP_AND:         ctrl.selAnd = 1'b1;
      OP_OR:          ctrl.selOr  = 1'b1;
      OP_SLT:         ctrl.selSlt = 1'b1;
      default:        ;
    endcase
  end

  // R8: never more than one result source
  always_comb begin
    p_onehot_sel_r8: assert ($onehot0({ctrl.selSum, ctrl.selAnd, ctrl.selOr, ctrl.selSlt}))
      else $error("R8: more than one result source selected");
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] result
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] effB;
  logic [WIDTH-1:0] sumBits;
  logic [WIDTH-1:0] carryVec;   // carry into each bit position
  logic             overflow;
  logic             lessBit;

  assign effB        = opB ^ {WIDTH{ctrl.invertB}};
  assign carryVec[0] = ctrl.carryIn;

  // ripple adder chain
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sumBits[i] = opA[i] ^ effB[i] ^ carryVec[i];
    if (i < WIDTH - 1) begin : g_carry
      assign carryVec[i+1] = (opA[i] & effB[i]) | (carryVec[i] & (opA[i] ^ effB[i]));
    end
  end

  // same-sign inputs with a sum of the opposite sign
  assign overflow = (opA[MSB] == effB[MSB]) && (sumBits[MSB] != opA[MSB]);
  assign lessBit  = sumBits[MSB] ^ overflow;

  always_comb begin
    result = ({WIDTH{ctrl.selSum}} & sumBits)
           | ({WIDTH{ctrl.selAnd}} & (opA & opB))
           | ({WIDTH{ctrl.selOr}}  & (opA | opB));
    result[0] = result[0] | (ctrl.selSlt & lessBit);
  end

  logic [WIDTH-1:0] refAdd;
  logic [WIDTH-1:0] refSub;
  assign refAdd = opA + opB;
  assign refSub = opA - opB;

  always_comb begin
    if (ctrl.selSum && !ctrl.invertB) begin
      p_sum_add_r1: assert (sumBits == refAdd) else $error("R1: adder mismatch");
    end
    if (ctrl.selSum && ctrl.invertB) begin
      p_sum_sub_r2: assert (sumBits == refSub) else $error("R2: subtract mismatch");
    end
    if (ctrl.selSlt) begin
      p_slt_signed_r5: assert (lessBit == ($signed(opA) < $signed(opB)))
        else $error("R5: compare bit disagrees with signed compare");
      p_slt_upper_r6: assert (result[MSB:1] == '0) else $error("R6: upper bits set");
    end
  end

endmodule

// File: rtl/alu32.sv
module alu32
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       opCode,
  output logic [WIDTH-1:0] result
);

  aluCtrl_t ctrl;

  alu_ctrl u_ctrl (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA    (opA),
    .opB    (opB),
    .ctrl   (ctrl),
    .result (result)
  );

  always_comb begin
    if (opCode == 3'b100 || opCode == 3'b110 || opCode == 3'b111) begin
      p_undef_zero_r7: assert (result == '0) else $error("R7: unassigned code gave nonzero");
    end
  end

endmodule

// File: tb/alu32_tb_top.sv
module alu32_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [2:0]  opCode = 3'b000;
  logic [31:0] result;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  alu32 dut_i (
    .opA    (opA),
    .opB    (opB),
    .opCode (opCode),
    .result (result)
  );

  function automatic logic [31:0] refModel(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    int signed sa;
    int signed sb;
    sa = a;
    sb = b;
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd5: return (sa < sb) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string reqTag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd5: return "R5/R6";
      default: return "R7";
    endcase
  endfunction

  task automatic runVec(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] expect_v;
    @(negedge clk);
    opCode = op;
    opA = a;
    opB = b;
    expect_v = refModel(op, a, b);
    @(posedge clk);
    #1;
    total++;
    if (result !== expect_v) begin
      bad++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h",
               reqTag(op), op, a, b, result, expect_v);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle state: zero operands, add gives zero
    runVec(3'd0, 32'h0, 32'h0);
    // R1 add with wrap
    runVec(3'd0, 32'd7, 32'd9);
    runVec(3'd0, 32'hFFFF_FFFF, 32'd1);
    runVec(3'd0, 32'h7FFF_FFFF, 32'd1);
    // R2 subtract with wrap
    runVec(3'd1, 32'd20, 32'd5);
    runVec(3'd1, 32'd0, 32'd1);
    runVec(3'd1, 32'h8000_0000, 32'd1);
    // R3 and, R4 or
    runVec(3'd2, 32'hF0F0_A5A5, 32'h0FF0_FFFF);
    runVec(3'd3, 32'hF0F0_0000, 32'h0F0F_1234);
    // R5 overflow corners and plain cases, R6 upper zero
    runVec(3'd5, 32'h8000_0000, 32'd1);
    runVec(3'd5, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    runVec(3'd5, 32'hFFFF_FFFF, 32'd0);
    runVec(3'd5, 32'd3, 32'd3);
    runVec(3'd5, 32'd2, 32'd3);
    runVec(3'd5, 32'h8000_0000, 32'h7FFF_FFFF);
    runVec(3'd5, 32'h7FFF_FFFF, 32'h8000_0000);
    // R7 unassigned codes with operands that would otherwise be nonzero
    runVec(3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    runVec(3'd6, 32'h1234_5678, 32'h8765_4321);
    runVec(3'd7, 32'h8000_0000, 32'd1);
    // mixed random sweep over every code
    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      op = 3'(n % 8);
      runVec(op, $urandom, $urandom);
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule